// File: doc/BRIEF.md
# Sixteen-Kilobyte Bank Switcher with Fixed Top Window

This block sits on a cartridge CPU bus and maps the 32 KB program window at $8000-$FFFF onto a larger program ROM. An 8-bit bank register selects a switchable 16 KB bank for the lower half of the window. The upper half always shows the last bank, because CPU address bit 14 is ORed into every ROM bank line. The same register also selects an 8 KB bank of character RAM and drives a one-screen mirroring select.

A static strap picks between two wirings. In the locked wiring, any write to the window loads the register. Because the ROM drives the bus at the same moment, the stored value is the AND of the CPU byte and the ROM byte. In the programmable wiring, only writes to the upper half load the register, and those writes see no conflict. Writes to the lower half become a ROM write strobe for a flash device instead. Further straps give the installed character RAM size and a half-size (256 KB) program ROM.

Every bus cycle is classified into one of four named cycle kinds:
- `CYC_IDLE`: ROM select inactive.
- `CYC_READ`: select active with R/W high.
- `CYC_LATCH`: a register-load write.
- `CYC_PROGRAM`: a flash strobe write.

The cycle kind depends only on the current inputs, so there are no transitions between kinds. The bank register is the only stored state.

Top module: `bank_mapper`

## Requirements
- R1: After reset the bank register is zero. With A14 low, the ROM bank lines read 0, and the mirroring output is 0.
- R2: Register field layout: bit 7 drives the one-screen mirroring output, bits 6..5 are the character bank, and bits 4..0 are the program bank.
- R3: Each ROM bank line k is the OR of CPU A14 and program bank bit k. With A14 high, all lines are 1 (last bank).
- R4: In the locked wiring (`cfg_flashable`=0), a write with `rom_sel_n` low loads the register at the next clock edge, whatever the value of A14.
- R5: In the locked wiring, the value loaded is `cpu_data` AND `rom_data`.
- R6: In the programmable wiring, a write with A14 high loads `cpu_data` unmodified.
- R7: In the programmable wiring, a write with A14 low drives `rom_we_n` low in that cycle and leaves the register unchanged. In the locked wiring, `rom_we_n` stays high.
- R8: `rom_oe_n` is low exactly when `rom_sel_n` is low and `cpu_rw` is 1 (read).
- R9: `rom_oe_n` and `rom_we_n` are never both low.
- R10: Character size code `cfg_chr_size`: 0 = 8 KB, 1 = 16 KB, 2 = 32 KB. Character line 0 is forced to 1 for code 0. Character line 1 is forced to 1 for codes 0 and 1. Otherwise each line follows its register bit.
- R11: With `cfg_prg_half`=1, the top ROM bank line is 0 and the lower four lines follow R3.
- R12: A write with `rom_sel_n` high, or any read, leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the register loads on its rising edge |
| rst_n | input | 1 | Active-low reset |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| rom_sel_n | input | 1 | Active-low select for $8000-$FFFF |
| cpu_data | input | 8 | CPU write data |
| rom_data | input | 8 | Byte the ROM drives at the current address |
| cfg_flashable | input | 1 | 1 = programmable wiring |
| cfg_prg_half | input | 1 | 1 = 256 KB program ROM |
| cfg_chr_size | input | 2 | Character RAM size code |
| rom_bank_addr | output | 5 | ROM address lines 18..14 |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_we_n | output | 1 | ROM write strobe, active low |
| chr_bank_addr | output | 2 | Character RAM address lines 14..13 |
| one_screen | output | 1 | One-screen mirroring select |

## Verification
In the programmable wiring, a lower-half write must assert the flash strobe in the same cycle that it must not load the register. In the locked wiring, the register load and the bus-conflict AND fall in the same cycle. The bench sweeps both wirings and both halves of the window over several data and ROM byte patterns. It checks `rom_we_n` and `rom_oe_n` during the write cycle itself. After the next edge, it reads the register fields back through the bank lines, with A14 low and then high, and compares them with a model that applies the AND and the load rules.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
    localparam int PRG_BITS_DEF = 5;
    localparam int CHR_BITS_DEF = 2;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_READ    = 2'd1,
        CYC_LATCH   = 2'd2,
        CYC_PROGRAM = 2'd3
    } cyc_e;
endpackage

// File: rtl/mapper_bus_decode.sv
module mapper_bus_decode
    import bank_mapper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_a14,
    input  logic cpu_rw,
    input  logic rom_sel_n,
    input  logic flashable,
    output cyc_e cyc,
    output logic rom_oe_n,
    output logic rom_we_n
);
    always_comb begin
        unique case ({rom_sel_n, cpu_rw})
            2'b10, 2'b11: cyc = CYC_IDLE;
            2'b01:        cyc = CYC_READ;
            default:      cyc = (flashable && !cpu_a14) ? CYC_PROGRAM : CYC_LATCH;
        endcase
    end

    always_comb begin
        rom_oe_n = 1'b1;
        rom_we_n = 1'b1;
        unique case (cyc)
            CYC_READ:    rom_oe_n = 1'b0;
            CYC_PROGRAM: rom_we_n = 1'b0;
            default:     ;
        endcase
    end

    // R7: the write strobe only fires in the programmable wiring, lower half
    a_r7_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_we_n |-> (flashable && !cpu_a14 && !cpu_rw && !rom_sel_n));
    // R8: output enable tied to a selected read
    a_r8_oe_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> (cpu_rw && !rom_sel_n));
endmodule

// File: rtl/mapper_bank_reg.sv
module mapper_bank_reg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             flashable,
    input  logic [REG_W-1:0] cpu_data,
    input  logic [REG_W-1:0] rom_data,
    output logic [REG_W-1:0] bank_q
);
    logic [REG_W-1:0] bank_d;

    always_comb begin
        bank_d = flashable ? cpu_data : (cpu_data & rom_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bank_q <= '0;
        else if (load) bank_q <= bank_d;
    end

    // R5: a locked-wiring load keeps only bits both drivers hold high
    a_r5_conflict_and: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !flashable) |=> ((bank_q & ~($past(cpu_data) & $past(rom_data))) == '0));
    // R6: a programmable load stores the CPU byte as written
    a_r6_clean_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && flashable) |=> (bank_q == $past(cpu_data)));
    // R12: without a load the register holds
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank_q));
endmodule

// File: rtl/mapper_addr_map.sv
module mapper_addr_map #(
    parameter int PRG_BITS = 5,
    parameter int CHR_BITS = 2
) (
    input  logic                cpu_a14,
    input  logic                prg_half,
    input  logic [1:0]          chr_size,
    input  logic [PRG_BITS-1:0] prg_bank,
    input  logic [CHR_BITS-1:0] chr_bank,
    output logic [PRG_BITS-1:0] rom_lines,
    output logic [CHR_BITS-1:0] chr_lines
);
    localparam int TOP = PRG_BITS - 1;

    for (genvar k = 0; k < PRG_BITS; k++) begin : g_prg
        if (k == TOP) begin : g_top
            assign rom_lines[k] = !prg_half && (cpu_a14 || prg_bank[k]);
        end else begin : g_low
            assign rom_lines[k] = cpu_a14 || prg_bank[k];
        end
    end

    // line j exists only when the installed size exceeds 8 KB << j
    for (genvar j = 0; j < CHR_BITS; j++) begin : g_chr
        assign chr_lines[j] = (int'(chr_size) <= j) ? 1'b1 : chr_bank[j];
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int PRG_BITS = PRG_BITS_DEF,
    parameter int CHR_BITS = CHR_BITS_DEF,
    localparam int REG_W   = PRG_BITS + CHR_BITS + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_a14,
    input  logic                cpu_rw,
    input  logic                rom_sel_n,
    input  logic [REG_W-1:0]    cpu_data,
    input  logic [REG_W-1:0]    rom_data,
    input  logic                cfg_flashable,
    input  logic                cfg_prg_half,
    input  logic [1:0]          cfg_chr_size,
    output logic [PRG_BITS-1:0] rom_bank_addr,
    output logic                rom_oe_n,
    output logic                rom_we_n,
    output logic [CHR_BITS-1:0] chr_bank_addr,
    output logic                one_screen
);
    cyc_e             cyc;
    logic [REG_W-1:0] bank_q;

    mapper_bus_decode i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_a14  (cpu_a14),
        .cpu_rw   (cpu_rw),
        .rom_sel_n(rom_sel_n),
        .flashable(cfg_flashable),
        .cyc      (cyc),
        .rom_oe_n (rom_oe_n),
        .rom_we_n (rom_we_n)
    );

    mapper_bank_reg #(.REG_W(REG_W)) i_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cyc == CYC_LATCH),
        .flashable(cfg_flashable),
        .cpu_data (cpu_data),
        .rom_data (rom_data),
        .bank_q   (bank_q)
    );

    mapper_addr_map #(.PRG_BITS(PRG_BITS), .CHR_BITS(CHR_BITS)) i_map (
        .cpu_a14  (cpu_a14),
        .prg_half (cfg_prg_half),
        .chr_size (cfg_chr_size),
        .prg_bank (bank_q[PRG_BITS-1:0]),
        .chr_bank (bank_q[PRG_BITS +: CHR_BITS]),
        .rom_lines(rom_bank_addr),
        .chr_lines(chr_bank_addr)
    );

    assign one_screen = bank_q[REG_W-1];

    // R9: the two ROM strobes are exclusive
    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_oe_n && !rom_we_n));
    // R3: the upper half of the window always shows the last bank
    a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_a14 && !cfg_prg_half) |-> (&rom_bank_addr));
    // R11: the top line is silent in a half-size build
    a_r11_top_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_prg_half |-> !rom_bank_addr[PRG_BITS-1]);
    // R4: a selected write in the locked wiring changes state only by loading
    a_r4_locked_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_flashable && !rom_sel_n && !cpu_rw) |=>
        (one_screen == ($past(cpu_data[REG_W-1]) & $past(rom_data[REG_W-1]))));
endmodule

// File: tb/test_bank_mapper.sv
module test_bank_mapper;
    localparam int CLK_PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       a14, rw, sel_n, flash, half;
    logic [7:0] d, rd;
    logic [1:0] csz;
    logic [4:0] rom_bank_addr;
    logic       rom_oe_n, rom_we_n, one_screen;
    logic [1:0] chr_bank_addr;

    int         n_chk = 0;
    int         n_err = 0;
    logic [7:0] model = 8'h00;

    bank_mapper i_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_a14(a14), .cpu_rw(rw), .rom_sel_n(sel_n),
        .cpu_data(d), .rom_data(rd), .cfg_flashable(flash), .cfg_prg_half(half),
        .cfg_chr_size(csz), .rom_bank_addr(rom_bank_addr), .rom_oe_n(rom_oe_n),
        .rom_we_n(rom_we_n), .chr_bank_addr(chr_bank_addr), .one_screen(one_screen)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // read back the register fields through the bank lines
    task automatic readback(input string req);
        @(negedge clk);
        a14 = 1'b0; rw = 1'b1; sel_n = 1'b0;
        #1;
        chk(req, {3'b0, rom_bank_addr}, {3'b0, half ? {1'b0, model[3:0]} : model[4:0]});
        chk(req, {7'b0, one_screen}, {7'b0, model[7]});
        if (csz == 2'd2) chk(req, {6'b0, chr_bank_addr}, {6'b0, model[6:5]});
        a14 = 1'b1;
        #1;
        chk("R3", {3'b0, rom_bank_addr}, half ? 8'h0F : 8'h1F);
    endtask

    task automatic do_write(input string req, input logic a, input logic [7:0] dv, input logic [7:0] rv);
        @(negedge clk);
        a14 = a; rw = 1'b0; sel_n = 1'b0; d = dv; rd = rv;
        #1;
        chk("R7", {7'b0, rom_we_n}, {7'b0, !(flash && !a)});
        chk("R8", {7'b0, rom_oe_n}, 8'h01);
        if (!flash)  model = dv & rv;
        else if (a)  model = dv;
        readback(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; a14 = 1'b0; rw = 1'b1; sel_n = 1'b1; flash = 1'b0;
        half = 1'b0; csz = 2'd2; d = 8'h00; rd = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        readback("R1");

        // R4 R5 R6 R7 R2: both wirings, both halves, several patterns
        for (int f = 0; f < 2; f++) begin
            flash = f[0];
            for (int a = 0; a < 2; a++) begin
                for (int v = 0; v < 8; v++) begin
                    logic [7:0] dv;
                    dv = 8'(v * 37 + 11) ^ 8'(v << 5);
                    for (int r = 0; r < 2; r++) begin
                        logic [7:0] rv;
                        rv = (r == 0) ? 8'hFF : 8'(8'h5A ^ 8'(v * 19));
                        if (f == 0)      do_write("R4 R5 R2", a[0], dv, rv);
                        else if (a == 1) do_write("R6 R2", 1'b1, dv, rv);
                        else             do_write("R7", 1'b0, dv, rv);
                    end
                end
            end
        end

        // R12: unselected writes and reads do not load
        flash = 1'b0;
        do_write("R4", 1'b1, 8'hA7, 8'hFF);
        @(negedge clk);
        a14 = 1'b1; rw = 1'b0; sel_n = 1'b1; d = 8'h18; rd = 8'hFF;
        @(negedge clk);
        a14 = 1'b0; rw = 1'b1; sel_n = 1'b0; d = 8'h3C;
        readback("R12");

        // R10: character size forcing
        flash = 1'b1;
        for (int s = 0; s < 3; s++) begin
            csz = 2'(s);
            for (int b = 0; b < 4; b++) begin
                do_write("R6", 1'b1, {1'b0, 2'(b), 5'd3}, 8'hFF);
                #1;
                chk("R10", {6'b0, chr_bank_addr},
                    {6'b0, (s <= 1) ? 1'b1 : b[1], (s == 0) ? 1'b1 : b[0]});
            end
        end
        csz = 2'd2;

        // R11: half-size program ROM
        half = 1'b1;
        do_write("R11", 1'b1, 8'h13, 8'hFF);
        half = 1'b0;
        readback("R11");

        // R8 R9 R7: decode sweep; select dropped before each edge
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            flash = c[3]; a14 = c[2]; rw = c[1]; sel_n = c[0];
            #1;
            chk("R8", {7'b0, rom_oe_n}, {7'b0, !(rw && !sel_n)});
            chk("R7", {7'b0, rom_we_n}, {7'b0, !(flash && !a14 && !rw && !sel_n)});
            chk("R9", {7'b0, rom_oe_n | rom_we_n}, 8'h01);
            #1;
            sel_n = 1'b1;
        end
        flash = 1'b1;
        readback("R12");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule